// File: doc/BRIEF.md
# CAN Receive Mailbox with Read-Side Locking

This block holds one receive slot of a CAN controller. A reception engine offers complete frames (identifier, length code and up to eight payload bytes) on a one-cycle valid strobe. The block copies each frame into the slot over a fixed number of clock cycles. While the copy is in progress, a busy bit is visible in the status word. When the copy ends, the block captures a 16-bit timestamp and raises an interrupt flag.

A host reads the slot through a small address/strobe port, and some reads have side effects. Reading the status word while busy is clear locks the slot, and the engine then leaves it untouched. Reading the free-running timer releases the lock. A frame that arrives while the slot is locked or busy waits in a single holding register, and a newer arrival replaces it. The slot remembers whether the host has serviced it. Two stores in a row without servicing in between give an overrun code. A store after servicing gives the plain full code again.

Top module: `can_rx_mailbox`

## Requirements
- R1: After reset, the status word (address 0) reads 32'h0400_0000: code 4'h4 (empty) in bits 27:24, busy bit 20 clear, length bits 19:16 zero and timestamp bits 15:0 zero. The identifier (address 1), data words (addresses 2 and 3) and flag (address 5) read zero, and irq is low.
- R2: A frame offered while the slot is unlocked, idle and not being read shows busy (bit 20) set from the next cycle for MOVE_CYCLES cycles. The stored contents and irq change at the end of that window.
- R3: Payload byte k of frm_data (bits 8k+7:8k) is stored big-endian: bytes 0..3 go to word 0 (address 2) and bytes 4..7 to word 1 (address 3), with byte 0 in bits 31:24 of word 0. Bytes at index ≥ the length code read zero. The length code is reported in status bits 19:16, and the identifier in bits 28:0 of address 1.
- R4: The timestamp field holds the timer value that the host would read in the last busy cycle, which is the value present at the storing edge.
- R5: The timer (address 4, bits 15:0) advances by one every BIT_CLKS clock cycles.
- R6: Reading the status word while busy is clear locks the slot. A frame that arrives while the slot is locked changes neither the stored contents nor irq.
- R7: Reading the timer unlocks the slot. A frame held during the lock is then stored, and of several frames held, only the latest is stored.
- R8: Reading the status word while busy is set does not lock the slot.
- R9: A store sets the code to 4'h6 (overrun) if the code was full (4'h2) or overrun and the slot has not been serviced since the previous store. Otherwise the store sets the code to 4'h2. A slot counts as serviced once a timer read releases a lock.
- R10: Each store sets the flag (address 5, bit 0), and irq follows it. Writing 1 in bit 0 to address 5 clears the flag, and writing 0 leaves it set.
- R11: When a status read and a frame arrive in the same cycle on a free slot, the read wins: the slot locks and the frame is held until the next unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe offering a frame |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Length code, 0 to 8 |
| frm_data | input | 64 | Payload, byte k in bits 8k+7:8k |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Register select: 0 status, 1 id, 2 word 0, 3 word 1, 4 timer, 5 flag |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr, valid in the same cycle |
| irq | output | 1 | Interrupt flag of the slot |

## Verification
The checker assumes that the engine never offers a length code above 8. It also assumes that the host issues at most one read or one write per cycle, and that a write to the flag register does not land in the same cycle as a store. Under these conditions, the checker can treat busy and locked as mutually exclusive and can rely on a flag clear being visible one cycle later. The bench sweeps every length from 0 to 8 and drives exactly one host action per cycle. It places each flag clear only after the move window has ended, so the stimulus stays inside these assumptions.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    typedef enum logic [3:0] {
        CODE_RX_FULL     = 4'h2,
        CODE_RX_EMPTY    = 4'h4,
        CODE_RX_OVERRUN  = 4'h6,
        CODE_TX_INACTIVE = 4'h8,
        CODE_TX_DATA     = 4'hC
    } mb_code_e;

    typedef struct packed {
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [63:0] bytes;
    } rx_frame_t;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_ID    = 3'd1;
    localparam logic [2:0] ADDR_DATA0 = 3'd2;
    localparam logic [2:0] ADDR_DATA1 = 3'd3;
    localparam logic [2:0] ADDR_TIMER = 3'd4;
    localparam logic [2:0] ADDR_FLAG  = 3'd5;

    // Big-endian packing of four payload bytes, zeroing those past the length.
    function automatic logic [31:0] be_word(input logic [63:0] bytes,
                                            input logic [3:0] dlc,
                                            input int w);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < 4; j++) begin
            if ((4 * w + j) < int'(dlc))
                r[31 - 8 * j -: 8] = bytes[8 * (4 * w + j) +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [3:0] code,
                                              input logic busy,
                                              input logic [3:0] dlc,
                                              input logic [15:0] ts);
        return {4'b0, code, 3'b0, busy, dlc, ts};
    endfunction

endpackage

// File: rtl/rxmb_timer.sv
module rxmb_timer #(
    parameter int BIT_CLKS = 4,
    parameter int TW       = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] count
);
    localparam int PW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [PW-1:0] PC_MAX = PW'(BIT_CLKS - 1);

    logic [PW-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            count <= '0;
        end else if (pc == PC_MAX) begin
            pc    <= '0;
            count <= count + 1'b1;
        end else begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/rxmb_intake.sv
module rxmb_intake
    import rxmb_pkg::*;
#(
    parameter int MOVE_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_valid,
    input  rx_frame_t frm_in,
    input  logic      mb_locked,
    input  logic      hold,
    output logic      busy,
    output logic      store_en,
    output rx_frame_t xfer
);
    localparam int CW = (MOVE_CYCLES > 1) ? $clog2(MOVE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(MOVE_CYCLES - 1);

    logic          pend_v;
    rx_frame_t     pend;
    logic [CW-1:0] cnt;
    logic          free;

    assign free     = !busy && !mb_locked && !hold;
    assign store_en = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
            busy   <= 1'b0;
            cnt    <= '0;
            xfer   <= '0;
        end else begin
            if (free && pend_v) begin
                xfer <= pend;
                busy <= 1'b1;
                cnt  <= CNT_INIT;
                if (frm_valid) pend <= frm_in;
                else           pend_v <= 1'b0;
            end else if (free && frm_valid) begin
                xfer <= frm_in;
                busy <= 1'b1;
                cnt  <= CNT_INIT;
            end else begin
                if (frm_valid) begin
                    pend   <= frm_in;
                    pend_v <= 1'b1;
                end
                if (busy) begin
                    if (cnt == '0) busy <= 1'b0;
                    else           cnt  <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
    import rxmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        store_en,
    input  rx_frame_t   xfer,
    input  logic [15:0] timer,
    input  logic        ctrl_rd,
    input  logic        timer_rd,
    input  logic        busy,
    input  logic        flag_clr,
    output logic        locked,
    output mb_code_e    code,
    output logic [28:0] mb_id,
    output logic [3:0]  mb_dlc,
    output logic [15:0] mb_ts,
    output logic [31:0] mb_w0,
    output logic [31:0] mb_w1,
    output logic        flag
);
    logic serviced;
    logic was_filled;

    assign was_filled = (code == CODE_RX_FULL) || (code == CODE_RX_OVERRUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            serviced <= 1'b0;
            code     <= CODE_RX_EMPTY;
            mb_id    <= '0;
            mb_dlc   <= '0;
            mb_ts    <= '0;
            mb_w0    <= '0;
            mb_w1    <= '0;
            flag     <= 1'b0;
        end else begin
            if (ctrl_rd && !busy)  locked <= 1'b1;
            else if (timer_rd)     locked <= 1'b0;

            if (store_en) begin
                serviced <= 1'b0;
                code     <= (was_filled && !serviced) ? CODE_RX_OVERRUN : CODE_RX_FULL;
                mb_id    <= xfer.id;
                mb_dlc   <= xfer.dlc;
                mb_ts    <= timer;
                mb_w0    <= be_word(xfer.bytes, xfer.dlc, 0);
                mb_w1    <= be_word(xfer.bytes, xfer.dlc, 1);
            end else if (timer_rd && locked) begin
                serviced <= 1'b1;
            end

            if (store_en)      flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
    import rxmb_pkg::*;
#(
    parameter int MOVE_CYCLES = 2,
    parameter int BIT_CLKS    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frm_valid,
    input  logic [28:0] frm_id,
    input  logic [3:0]  frm_dlc,
    input  logic [63:0] frm_data,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq
);
    localparam int TS_W = 16;

    rx_frame_t        frm_in;
    rx_frame_t        xfer;
    logic             busy;
    logic             store_en;
    logic             locked;
    mb_code_e         code;
    logic [28:0]      mb_id;
    logic [3:0]       mb_dlc;
    logic [TS_W-1:0]  mb_ts;
    logic [31:0]      mb_w0;
    logic [31:0]      mb_w1;
    logic [TS_W-1:0]  timer;
    logic             ctrl_rd;
    logic             timer_rd;
    logic             flag_clr;
    logic             unused_wdata;

    assign frm_in       = '{id: frm_id, dlc: frm_dlc, bytes: frm_data};
    assign ctrl_rd      = host_rd && (host_addr == ADDR_CTRL);
    assign timer_rd     = host_rd && (host_addr == ADDR_TIMER);
    assign flag_clr     = host_wr && (host_addr == ADDR_FLAG) && host_wdata[0];
    assign unused_wdata = ^host_wdata[31:1];

    rxmb_timer #(.BIT_CLKS(BIT_CLKS), .TW(TS_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .count (timer)
    );

    rxmb_intake #(.MOVE_CYCLES(MOVE_CYCLES)) u_intake (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frm_in    (frm_in),
        .mb_locked (locked),
        .hold      (ctrl_rd),
        .busy      (busy),
        .store_en  (store_en),
        .xfer      (xfer)
    );

    rxmb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .store_en (store_en),
        .xfer     (xfer),
        .timer    (timer),
        .ctrl_rd  (ctrl_rd),
        .timer_rd (timer_rd),
        .busy     (busy),
        .flag_clr (flag_clr),
        .locked   (locked),
        .code     (code),
        .mb_id    (mb_id),
        .mb_dlc   (mb_dlc),
        .mb_ts    (mb_ts),
        .mb_w0    (mb_w0),
        .mb_w1    (mb_w1),
        .flag     (irq)
    );

    always_comb begin
        case (host_addr)
            ADDR_CTRL:  host_rdata = ctrl_word(code, busy, mb_dlc, mb_ts);
            ADDR_ID:    host_rdata = {3'b0, mb_id};
            ADDR_DATA0: host_rdata = mb_w0;
            ADDR_DATA1: host_rdata = mb_w1;
            ADDR_TIMER: host_rdata = {16'b0, timer};
            ADDR_FLAG:  host_rdata = {31'b0, irq};
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxmb_chk.sv
module rxmb_chk
    import rxmb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        locked,
    input logic        store_en,
    input logic        irq,
    input logic        host_rd,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic [28:0] mb_id,
    input logic [3:0]  code
);
    // R6
    busy_excl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !locked);

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(mb_id));

    // R7
    timer_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == ADDR_TIMER) |=> !locked);

    // R8
    busy_read_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == ADDR_CTRL && busy) |=> !locked);

    // R10
    store_flag_chk: assert property (@(posedge clk) disable iff (rst)
        store_en |=> irq);

    // R10
    clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_FLAG && host_wdata[0] && !store_en) |=> !irq);

    // R9
    flag_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (code == CODE_RX_FULL || code == CODE_RX_OVERRUN));
endmodule

bind can_rx_mailbox rxmb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .locked     (locked),
    .store_en   (store_en),
    .irq        (irq),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mb_id      (mb_id),
    .code       (code)
);

// File: tb/can_rx_mailbox_test.sv
`timescale 1ns/1ps
module can_rx_mailbox_test;
    localparam int MV = 2;
    localparam int BC = 4;
    localparam logic [2:0] A_CTRL = 3'd0, A_ID = 3'd1, A_D0 = 3'd2,
                           A_D1 = 3'd3, A_TMR = 3'd4, A_FLG = 3'd5;
    localparam logic [3:0] C_EMPTY = 4'h4, C_FULL = 4'h2, C_OVR = 4'h6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] rv;
    logic [3:0]  exp_code = C_EMPTY;
    bit exp_serv = 0;
    bit exp_locked = 0;

    always #4 clk = ~clk;

    can_rx_mailbox #(.MOVE_CYCLES(MV), .BIT_CLKS(BC)) uut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_dlc(frm_dlc), .frm_data(frm_data), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input bit rd, input bit wr, input logic [2:0] a, input logic [31:0] wd,
                        input bit fv, input logic [28:0] id, input logic [3:0] dlc,
                        input logic [63:0] dat);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
        frm_valid = fv; frm_id = id; frm_dlc = dlc; frm_data = dat;
        #1 rv = host_rdata;
    endtask

    task automatic idle();
        step(0, 0, 3'd0, 32'd0, 0, 29'd0, 4'd0, 64'd0);
    endtask

    task automatic rd(input logic [2:0] a);
        step(1, 0, a, 32'd0, 0, 29'd0, 4'd0, 64'd0);
    endtask

    task automatic frame(input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] dat);
        step(0, 0, 3'd0, 32'd0, 1, id, dlc, dat);
    endtask

    task automatic model_store();
        exp_code = ((exp_code == C_FULL || exp_code == C_OVR) && !exp_serv) ? C_OVR : C_FULL;
        exp_serv = 0;
    endtask

    task automatic unlock();
        rd(A_TMR);
        if (exp_locked) exp_serv = 1;
        exp_locked = 0;
        idle();
    endtask

    task automatic clr();
        step(0, 1, A_FLG, 32'd1, 0, 29'd0, 4'd0, 64'd0);
        idle();
        rd(A_FLG);
        chk("R10 flag cleared by writing 1", rv, 32'd0);
        idle();
    endtask

    function automatic logic [63:0] be64(input logic [63:0] dat, input logic [3:0] dlc);
        logic [63:0] b;
        b = '0;
        for (int k = 0; k < 8; k++)
            if (k < int'(dlc)) b[63 - 8 * k -: 8] = dat[8 * k +: 8];
        return b;
    endfunction

    task automatic check_after(input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] dat);
        logic [63:0] b;
        b = be64(dat, dlc);
        rd(A_ID);  chk("R3 identifier", rv, {3'b0, id});
        rd(A_D0);  chk("R3 word0 big-endian", rv, b[63:32]);
        rd(A_D1);  chk("R3 word1 big-endian", rv, b[31:0]);
        rd(A_FLG); chk("R10 flag set on store", rv, 32'd1);
        chk("R10 irq follows flag", {31'b0, irq}, 32'd1);
    endtask

    task automatic send(input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] dat,
                        input bit look);
        logic [15:0] t;
        frame(id, dlc, dat);
        for (int i = 1; i < MV; i++) begin
            rd(A_CTRL);
            chk("R2 busy during move", {31'b0, rv[20]}, 32'd1);
        end
        rd(A_TMR);
        t = rv[15:0];
        model_store();
        check_after(id, dlc, dat);
        if (look) begin
            rd(A_CTRL);
            chk("R2 R4 R9 status after store", rv, {4'b0, exp_code, 3'b0, 1'b0, dlc, t});
            exp_locked = 1;
        end
    endtask

    initial begin
        logic [63:0] dat;
        logic [31:0] ta;
        rst = 1'b1;
        repeat (3) idle();
        rst = 1'b0;
        idle();
        // R1 reset state
        chk("R1 irq low", {31'b0, irq}, 32'd0);
        rd(A_ID);  chk("R1 id zero", rv, 32'd0);
        rd(A_D0);  chk("R1 word0 zero", rv, 32'd0);
        rd(A_D1);  chk("R1 word1 zero", rv, 32'd0);
        rd(A_FLG); chk("R1 flag zero", rv, 32'd0);
        rd(A_CTRL); chk("R1 status word", rv, 32'h0400_0000);
        exp_locked = 1;
        unlock();

        // R5 timer rate
        rd(A_TMR); ta = rv;
        repeat (3 * BC - 1) idle();
        rd(A_TMR);
        chk("R5 timer advance", rv - ta, 32'd3);
        idle();

        // R3 R4 sweep over every length
        for (int d = 0; d <= 8; d++) begin
            for (int k = 0; k < 8; k++) dat[8 * k +: 8] = {4'(d), 4'(k)} ^ 8'h5A;
            send(29'h1ABC_D000 | 29'(d), 4'(d), dat, 1);
            chk("R9 code full after serviced store", {28'b0, rv[27:24]}, {28'b0, C_FULL});
            if (d == 3) begin
                step(0, 1, A_FLG, 32'd0, 0, 29'd0, 4'd0, 64'd0);
                idle();
                rd(A_FLG);
                chk("R10 writing 0 keeps flag", rv, 32'd1);
            end
            unlock();
            clr();
        end

        // R9 overrun and recovery
        send(29'h0000_0AAA, 4'd2, 64'h1111_2222_3333_4444, 0);
        send(29'h0000_0BBB, 4'd8, 64'h5555_6666_7777_8888, 0);
        rd(A_CTRL);
        chk("R9 overrun code", {28'b0, rv[27:24]}, {28'b0, C_OVR});
        exp_locked = 1;
        unlock();
        clr();
        send(29'h0000_0CCC, 4'd4, 64'h0102_0304_0506_0708, 1);
        chk("R9 full after service", {28'b0, rv[27:24]}, {28'b0, C_FULL});

        // R6 R7 lock holds off frames; latest pending wins
        clr();
        frame(29'h0000_0DDD, 4'd8, 64'hDEAD_BEEF_0000_1111);
        repeat (MV + 3) idle();
        chk("R6 irq unchanged while locked", {31'b0, irq}, 32'd0);
        rd(A_ID); chk("R6 id unchanged while locked", rv, 32'h0000_0CCC);
        dat = be64(64'h0102_0304_0506_0708, 4'd4);
        rd(A_D0); chk("R6 word0 unchanged while locked", rv, dat[63:32]);
        frame(29'h0000_0EEE, 4'd3, 64'h0000_0000_00C3_B2A1);
        idle();
        unlock();
        repeat (MV + 3) idle();
        model_store();
        check_after(29'h0000_0EEE, 4'd3, 64'h0000_0000_00C3_B2A1);
        rd(A_CTRL);
        chk("R7 code after release", {28'b0, rv[27:24]}, {28'b0, exp_code});
        chk("R7 busy clear", {31'b0, rv[20]}, 32'd0);
        exp_locked = 1;
        unlock();
        clr();

        // R8 read during busy does not lock
        send(29'h0000_0F0F, 4'd1, 64'h0000_0000_0000_0077, 0);
        send(29'h0000_0666, 4'd5, 64'h0000_00AB_CDEF_1234, 0);
        rd(A_CTRL);
        chk("R8 second frame stored, overrun", {28'b0, rv[27:24]}, {28'b0, C_OVR});
        exp_locked = 1;
        unlock();
        clr();

        // R11 status read beats a simultaneous frame
        step(1, 0, A_CTRL, 32'd0, 1, 29'h0000_0777, 4'd6, 64'h0000_6655_4433_2211);
        exp_locked = 1;
        repeat (MV + 2) idle();
        rd(A_ID); chk("R11 frame held while read wins", rv, 32'h0000_0666);
        chk("R11 irq still low", {31'b0, irq}, 32'd0);
        unlock();
        repeat (MV + 3) idle();
        model_store();
        check_after(29'h0000_0777, 4'd6, 64'h0000_6655_4433_2211);
        idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule